// File: doc/BRIEF.md
# Packet DMA Channel Register Block

This block is the host-visible register file for a two-channel, packet-driven disk DMA engine. The host reaches it through a simple word-wide request port carrying a byte address and byte enables. Each channel exposes the following registers:

- a 16-bit control word that starts packet processing, resets the engine, masks the interrupt and selects the PIO timing mode;
- a status byte that gathers error events reported by the engine;
- a 16-bit descriptor count;
- a 32-bit next-descriptor pointer;
- a pair of 16-bit FIFO threshold words.

A single global key byte has to be written with a fixed value before any start request can reach the engine.

Each channel runs a small state machine with three states:

- `CH_IDLE`: the default state.
- `CH_FIRE`: lasts one cycle, during which the go pulse is driven.
- `CH_HELD`: the engine reset is held.

Transitions happen only on a write to the control word's low byte:

- A write with the reset bit set goes to `CH_HELD`.
- Otherwise, a write with the start bit set while the key is latched goes to `CH_FIRE`.
- Any other such write goes to `CH_IDLE`.

With no such write, `CH_FIRE` falls back to `CH_IDLE`, and `CH_HELD` stays where it is.

The key latch has two states, `LK_OPEN` and `LK_SET`. It moves `LK_OPEN` -> `LK_SET` on a write of 0x07 to byte 0xC7. It never leaves `LK_SET` until system reset.

Status bits accumulate until the host reads the status byte. That read returns the bits and clears them. A per-channel interrupt is raised while any status bit is set and the mask bit is clear.

Top module: `pkt_dma_regs`

## Requirements
- R1: Channel n occupies byte addresses 0x80 + n*0x20 onward: control word at +0x00 (lanes 1:0), status at +0x02 (lane 2), descriptor count at +0x04, pointer at +0x0C, input threshold at +0x14 (lanes 1:0), output threshold at +0x16 (lanes 3:2). Written bytes read back in the same lanes, only enabled lanes change, and the count and thresholds also appear on the output ports.
- R2: Control bits 1:0 set the PIO mode output and bit 8 is the interrupt mask. Control reads as {7'b0, mask, 2'b0, reset, 3'b0, pio}, so the start bit (7) always reads 0.
- R3: A control write with lane 0 enabled, bit 7 = 1 and bit 5 = 0, made while the key is latched, drives go_pulse high for exactly the following cycle. Two such writes in a row give two pulses.
- R4: Writing 0x07 to byte 0xC7 (lane 3 of word 0xC4) latches the key permanently, and the byte then reads 0x07. Writing any other value leaves the key open, and a start request made while the key is open produces no pulse.
- R5: The engine events each set one status bit, and the bits accumulate:
  - host/bus error sets bit 0;
  - unexpected device interrupt sets bit 4;
  - packet-state fault sets bit 6.
- R6: A read with lane 2 enabled on a channel's control word returns the status accumulated before the read and clears it. Events arriving in the same cycle as that read are kept. A read without lane 2 does not clear.
- R7: While control bit 5 is 1, eng_reset is high, the status stays 0, events are ignored and no go pulse is produced.
- R8: irq for a channel is high exactly when its status is non-zero and its mask bit is 0.
- R9: The low 3 bits of the next-descriptor pointer always read and drive 0, whatever value is written.
- R10: Accesses to one channel leave the other channel's registers and outputs unchanged.
- R11: Every read request gives bus_rvalid and its bus_rdata one cycle later, and unmapped addresses read as 0. After reset, all registers and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (bits 1:0 ignored) |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| evt_host_err | input | 2 | Per-channel host/bus error event |
| evt_unexp_irq | input | 2 | Per-channel unexpected device interrupt event |
| evt_pkt_fault | input | 2 | Per-channel packet-state fault event |
| go_pulse | output | 2 | Per-channel one-cycle start strobe |
| eng_reset | output | 2 | Per-channel engine reset level |
| irq | output | 2 | Per-channel interrupt request |
| pio_mode | output | 4 | Per-channel PIO mode, 2 bits each |
| desc_count | output | 32 | Per-channel descriptor count, 16 bits each |
| desc_ptr | output | 64 | Per-channel next-descriptor pointer, 32 bits each |
| fifo_in_thr | output | 32 | Per-channel input FIFO threshold |
| fifo_out_thr | output | 32 | Per-channel output FIFO threshold |

## Verification
The hardest case is a status read that collides with a new event in the same cycle. The read must return only the older bits while the new bit survives for the next read. The stimulus first builds up a status value, then issues the lane-2 read with a different event asserted in that same cycle. A second read then shows only the surviving bit. Start requests are exercised in three situations (before the key is latched, after a wrong key value, and together with the reset bit) so that the gating of the go pulse is seen from its outputs.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_FIRE = 2'd1,
        CH_HELD = 2'd2
    } ch_state_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SET  = 1'b1
    } lock_state_e;

    localparam int CTRL_PIO_LSB  = 0;
    localparam int CTRL_RST_BIT  = 5;
    localparam int CTRL_GO_BIT   = 7;
    localparam int CTRL_MASK_BIT = 8;

    localparam int ST_HOST_BIT  = 0;
    localparam int ST_UNEXP_BIT = 4;
    localparam int ST_FAULT_BIT = 6;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_CNT  = 8'h04;
    localparam logic [7:0] OFF_PTR  = 8'h0C;
    localparam logic [7:0] OFF_THR  = 8'h14;

endpackage

// File: rtl/pdr_lock.sv
module pdr_lock
    import pdr_pkg::*;
#(
    parameter logic [7:0] KEY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       locked
);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (key_wr && key_val == KEY) state_d = LK_SET;
            LK_SET:  state_d = LK_SET;
            default: state_d = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        locked = (state_q == LK_SET);
    end

    // key stays latched once set
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

endmodule

// File: rtl/pdr_channel.sv
module pdr_channel
    import pdr_pkg::*;
#(
    parameter int PIO_W      = 2,
    parameter int CNT_W      = 16,
    parameter int PTR_W      = 32,
    parameter int THR_W      = 16,
    parameter int ALIGN_BITS = 3,
    parameter int DW         = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_we_lo,
    input  logic                   ctrl_we_hi,
    input  logic                   stat_rd,
    input  logic [CNT_W/8-1:0]     cnt_be,
    input  logic [PTR_W/8-1:0]     ptr_be,
    input  logic [2*THR_W/8-1:0]   thr_be,
    input  logic [DW-1:0]          wdata,
    input  logic                   lock,
    input  logic                   ev_host,
    input  logic                   ev_unexp,
    input  logic                   ev_fault,
    output logic                   go,
    output logic                   held,
    output logic                   irq,
    output logic [PIO_W-1:0]       pio,
    output logic [7:0]             stat_byte,
    output logic [15:0]            ctrl_word,
    output logic [CNT_W-1:0]       cnt,
    output logic [PTR_W-1:0]       ptr,
    output logic [THR_W-1:0]       thr_in,
    output logic [THR_W-1:0]       thr_out
);

    localparam int CNT_B = CNT_W / 8;
    localparam int PTR_B = PTR_W / 8;
    localparam int THR_B = THR_W / 8;

    ch_state_e        state_q, state_d;
    logic             mask_q;
    logic [PIO_W-1:0] pio_q;
    logic [2:0]       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [THR_W-1:0] tin_q, tin_d, tout_q, tout_d;

    // channel state transitions
    always_comb begin
        state_d = state_q;
        if (ctrl_we_lo) begin
            if (wdata[CTRL_RST_BIT])                state_d = CH_HELD;
            else if (wdata[CTRL_GO_BIT] && lock)    state_d = CH_FIRE;
            else                                    state_d = CH_IDLE;
        end else begin
            unique case (state_q)
                CH_IDLE: state_d = CH_IDLE;
                CH_FIRE: state_d = CH_IDLE;
                CH_HELD: state_d = CH_HELD;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // status accumulation, read-clear and reset hold
    always_comb begin
        if (state_d == CH_HELD) st_d = '0;
        else st_d = (stat_rd ? 3'b000 : st_q) | {ev_fault, ev_unexp, ev_host};
    end

    // byte-lane register updates
    always_comb begin
        cnt_d  = cnt_q;
        ptr_d  = ptr_q;
        tin_d  = tin_q;
        tout_d = tout_q;
        for (int b = 0; b < CNT_B; b++)
            if (cnt_be[b]) cnt_d[b*8 +: 8] = wdata[b*8 +: 8];
        for (int b = 0; b < PTR_B; b++)
            if (ptr_be[b]) ptr_d[b*8 +: 8] = wdata[b*8 +: 8];
        for (int b = 0; b < THR_B; b++) begin
            if (thr_be[b])         tin_d[b*8 +: 8]  = wdata[b*8 +: 8];
            if (thr_be[THR_B + b]) tout_d[b*8 +: 8] = wdata[THR_W + b*8 +: 8];
        end
        ptr_d[ALIGN_BITS-1:0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            pio_q  <= '0;
            st_q   <= '0;
            cnt_q  <= '0;
            ptr_q  <= '0;
            tin_q  <= '0;
            tout_q <= '0;
        end else begin
            if (ctrl_we_lo) pio_q  <= wdata[CTRL_PIO_LSB +: PIO_W];
            if (ctrl_we_hi) mask_q <= wdata[CTRL_MASK_BIT];
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            ptr_q  <= ptr_d;
            tin_q  <= tin_d;
            tout_q <= tout_d;
        end
    end

    // outputs
    always_comb begin
        go        = (state_q == CH_FIRE);
        held      = (state_q == CH_HELD);
        irq       = (|st_q) && !mask_q;
        pio       = pio_q;
        stat_byte = '0;
        stat_byte[ST_HOST_BIT]  = st_q[0];
        stat_byte[ST_UNEXP_BIT] = st_q[1];
        stat_byte[ST_FAULT_BIT] = st_q[2];
        ctrl_word = '0;
        ctrl_word[CTRL_PIO_LSB +: PIO_W] = pio_q;
        ctrl_word[CTRL_RST_BIT]  = held;
        ctrl_word[CTRL_MASK_BIT] = mask_q;
        cnt     = cnt_q;
        ptr     = ptr_q;
        thr_in  = tin_q;
        thr_out = tout_q;
    end

    assert_go_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> lock);

    assert_go_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (!go || $past(ctrl_we_lo)));

    assert_held_no_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (st_q == 3'b000 && !go));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ev_host && !ev_unexp && !ev_fault) |=> (st_q == 3'b000));

endmodule

// File: rtl/pkt_dma_regs.sv
module pkt_dma_regs
    import pdr_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CH_BASE   = 'h80,
    parameter int CH_STRIDE = 'h20,
    parameter int LOCK_ADDR = 'hC7,
    parameter logic [7:0] LOCK_KEY = 8'h07,
    parameter int PIO_W     = 2,
    parameter int CNT_W     = 16,
    parameter int PTR_W     = 32,
    parameter int THR_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [7:0]              bus_addr,
    input  logic [3:0]              bus_be,
    input  logic [31:0]             bus_wdata,
    output logic                    bus_rvalid,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_CH-1:0]       evt_host_err,
    input  logic [NUM_CH-1:0]       evt_unexp_irq,
    input  logic [NUM_CH-1:0]       evt_pkt_fault,
    output logic [NUM_CH-1:0]       go_pulse,
    output logic [NUM_CH-1:0]       eng_reset,
    output logic [NUM_CH-1:0]       irq,
    output logic [NUM_CH*PIO_W-1:0] pio_mode,
    output logic [NUM_CH*CNT_W-1:0] desc_count,
    output logic [NUM_CH*PTR_W-1:0] desc_ptr,
    output logic [NUM_CH*THR_W-1:0] fifo_in_thr,
    output logic [NUM_CH*THR_W-1:0] fifo_out_thr
);

    localparam int         DW        = 32;
    localparam logic [7:0] LOCK_A    = 8'(LOCK_ADDR);
    localparam logic [7:0] LOCK_WORD = {LOCK_A[7:2], 2'b00};
    localparam int         LOCK_LANE = LOCK_ADDR % 4;

    function automatic logic [7:0] chan_base(input int c);
        return 8'(CH_BASE + c * CH_STRIDE);
    endfunction

    logic [7:0] wa;
    logic       wr, rd, locked;

    assign wa = {bus_addr[7:2], 2'b00};
    assign wr = bus_req && bus_we;
    assign rd = bus_req && !bus_we;

    pdr_lock #(.KEY(LOCK_KEY)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (wr && wa == LOCK_WORD && bus_be[LOCK_LANE]),
        .key_val (bus_wdata[LOCK_LANE*8 +: 8]),
        .locked  (locked)
    );

    logic [15:0]      ch_ctrl [NUM_CH];
    logic [7:0]       ch_stat [NUM_CH];
    logic [CNT_W-1:0] ch_cnt  [NUM_CH];
    logic [PTR_W-1:0] ch_ptr  [NUM_CH];
    logic [THR_W-1:0] ch_tin  [NUM_CH];
    logic [THR_W-1:0] ch_tout [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [7:0] CB = chan_base(g);
        logic hit_ctrl, hit_cnt, hit_ptr, hit_thr;
        assign hit_ctrl = wa == 8'(CB + OFF_CTRL);
        assign hit_cnt  = wa == 8'(CB + OFF_CNT);
        assign hit_ptr  = wa == 8'(CB + OFF_PTR);
        assign hit_thr  = wa == 8'(CB + OFF_THR);

        pdr_channel #(
            .PIO_W(PIO_W), .CNT_W(CNT_W), .PTR_W(PTR_W), .THR_W(THR_W),
            .ALIGN_BITS(3), .DW(DW)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we_lo (wr && hit_ctrl && bus_be[0]),
            .ctrl_we_hi (wr && hit_ctrl && bus_be[1]),
            .stat_rd    (rd && hit_ctrl && bus_be[2]),
            .cnt_be     ((wr && hit_cnt) ? bus_be[CNT_W/8-1:0] : '0),
            .ptr_be     ((wr && hit_ptr) ? bus_be[PTR_W/8-1:0] : '0),
            .thr_be     ((wr && hit_thr) ? bus_be[2*THR_W/8-1:0] : '0),
            .wdata      (bus_wdata),
            .lock       (locked),
            .ev_host    (evt_host_err[g]),
            .ev_unexp   (evt_unexp_irq[g]),
            .ev_fault   (evt_pkt_fault[g]),
            .go         (go_pulse[g]),
            .held       (eng_reset[g]),
            .irq        (irq[g]),
            .pio        (pio_mode[g*PIO_W +: PIO_W]),
            .stat_byte  (ch_stat[g]),
            .ctrl_word  (ch_ctrl[g]),
            .cnt        (ch_cnt[g]),
            .ptr        (ch_ptr[g]),
            .thr_in     (ch_tin[g]),
            .thr_out    (ch_tout[g])
        );

        assign desc_count[g*CNT_W +: CNT_W]   = ch_cnt[g];
        assign desc_ptr[g*PTR_W +: PTR_W]     = ch_ptr[g];
        assign fifo_in_thr[g*THR_W +: THR_W]  = ch_tin[g];
        assign fifo_out_thr[g*THR_W +: THR_W] = ch_tout[g];
    end

    logic [DW-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wa == 8'(chan_base(c) + OFF_CTRL)) rd_mux = {8'h00, ch_stat[c], ch_ctrl[c]};
            if (wa == 8'(chan_base(c) + OFF_CNT))  rd_mux = DW'(ch_cnt[c]);
            if (wa == 8'(chan_base(c) + OFF_PTR))  rd_mux = DW'(ch_ptr[c]);
            if (wa == 8'(chan_base(c) + OFF_THR))  rd_mux = DW'({ch_tout[c], ch_tin[c]});
        end
        if (wa == LOCK_WORD) rd_mux[LOCK_LANE*8 +: 8] = locked ? LOCK_KEY : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd;
            bus_rdata  <= rd ? rd_mux : '0;
        end
    end

    assert_read_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_no_idle_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_rvalid);

endmodule

// File: tb/tb_pkt_dma_regs.sv
module tb_pkt_dma_regs;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [1:0]  evt_host_err = '0, evt_unexp_irq = '0, evt_pkt_fault = '0;
    logic [1:0]  go_pulse, eng_reset, irq;
    logic [3:0]  pio_mode;
    logic [31:0] desc_count, fifo_in_thr, fifo_out_thr;
    logic [63:0] desc_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_dma_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .evt_host_err(evt_host_err), .evt_unexp_irq(evt_unexp_irq),
        .evt_pkt_fault(evt_pkt_fault), .go_pulse(go_pulse), .eng_reset(eng_reset),
        .irq(irq), .pio_mode(pio_mode), .desc_count(desc_count), .desc_ptr(desc_ptr),
        .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    // behavioural reference state
    bit        m_mask [2], m_held [2], m_go [2];
    bit [1:0]  m_pio  [2];
    bit [7:0]  m_st   [2];
    bit [15:0] m_cnt  [2], m_tin [2], m_tout [2];
    bit [31:0] m_ptr  [2];
    bit        m_lock, m_rv;
    bit [31:0] m_rd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] model_read(input bit [7:0] a);
        bit [31:0] r = 0;
        bit [7:0]  w = {a[7:2], 2'b00};
        for (int c = 0; c < 2; c++) begin
            bit [7:0] b = 8'(8'h80 + c * 8'h20);
            bit [15:0] cw = {7'b0, m_mask[c], 2'b0, m_held[c], 3'b0, m_pio[c]};
            if (w == b)               r = {8'h00, m_st[c], cw};
            if (w == 8'(b + 8'h04))   r = {16'h0, m_cnt[c]};
            if (w == 8'(b + 8'h0C))   r = m_ptr[c];
            if (w == 8'(b + 8'h14))   r = {m_tout[c], m_tin[c]};
        end
        if (w == 8'hC4) r = {(m_lock ? 8'h07 : 8'h00), 24'h0};
        return r;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_mask[c] = 0; m_held[c] = 0; m_go[c] = 0; m_pio[c] = 0; m_st[c] = 0;
            m_cnt[c] = 0; m_tin[c] = 0; m_tout[c] = 0; m_ptr[c] = 0;
        end
        m_lock = 0; m_rv = 0; m_rd = 0;
    endtask

    task automatic model_step(input bit req, input bit we, input bit [7:0] a,
                              input bit [3:0] be, input bit [31:0] d,
                              input bit [1:0] eh, input bit [1:0] eu, input bit [1:0] ef);
        bit [7:0] w = {a[7:2], 2'b00};
        bit rdop = req && !we;
        bit wrop = req && we;
        m_rd = rdop ? model_read(a) : 32'h0;
        m_rv = rdop;
        for (int c = 0; c < 2; c++) begin
            bit [7:0] b = 8'(8'h80 + c * 8'h20);
            bit [7:0] ev = {1'b0, ef[c], 1'b0, eu[c], 3'b0, eh[c]};
            bit clr = rdop && w == b && be[2];
            m_go[c] = 0;
            if (wrop && w == b && be[0]) begin
                m_held[c] = d[5];
                m_go[c]   = !d[5] && d[7] && m_lock;
                m_pio[c]  = d[1:0];
            end
            if (wrop && w == b && be[1]) m_mask[c] = d[8];
            if (m_held[c]) m_st[c] = 0;
            else m_st[c] = (clr ? 8'h00 : m_st[c]) | ev;
            for (int k = 0; k < 2; k++) begin
                if (wrop && w == 8'(b + 8'h04) && be[k]) m_cnt[c][k*8 +: 8] = d[k*8 +: 8];
                if (wrop && w == 8'(b + 8'h14) && be[k]) m_tin[c][k*8 +: 8] = d[k*8 +: 8];
                if (wrop && w == 8'(b + 8'h14) && be[k+2]) m_tout[c][k*8 +: 8] = d[16 + k*8 +: 8];
            end
            for (int k = 0; k < 4; k++)
                if (wrop && w == 8'(b + 8'h0C) && be[k]) m_ptr[c][k*8 +: 8] = d[k*8 +: 8];
            m_ptr[c][2:0] = 3'b000;
        end
        if (wrop && w == 8'hC4 && be[3] && d[31:24] == 8'h07) m_lock = 1;
    endtask

    task automatic compare(input string tag);
        for (int c = 0; c < 2; c++) begin
            chk("R3 go_pulse",   32'(go_pulse[c]),  32'(m_go[c]));
            chk("R7 eng_reset",  32'(eng_reset[c]), 32'(m_held[c]));
            chk("R8 irq",        32'(irq[c]),       32'(m_st[c] != 0 && !m_mask[c]));
            chk("R2 pio_mode",   32'(pio_mode[c*2 +: 2]), 32'(m_pio[c]));
            chk("R1 desc_count", 32'(desc_count[c*16 +: 16]), 32'(m_cnt[c]));
            chk("R9 desc_ptr",   desc_ptr[c*32 +: 32], m_ptr[c]);
            chk("R1 fifo_thr",   {fifo_out_thr[c*16 +: 16], fifo_in_thr[c*16 +: 16]},
                                 {m_tout[c], m_tin[c]});
        end
        chk({tag, " rvalid"}, 32'(bus_rvalid), 32'(m_rv));
        chk({tag, " rdata"},  bus_rdata, m_rd);
    endtask

    // one cycle: compare state left by the last edge, then drive and predict
    task automatic step(input bit req, input bit we, input bit [7:0] a, input bit [3:0] be,
                        input bit [31:0] d, input bit [1:0] eh, input bit [1:0] eu,
                        input bit [1:0] ef, input string tag);
        @(negedge clk);
        compare(tag);
        bus_req = req; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
        evt_host_err = eh; evt_unexp_irq = eu; evt_pkt_fault = ef;
        model_step(req, we, a, be, d, eh, eu, ef);
    endtask

    task automatic wr(input bit [7:0] a, input bit [3:0] be, input bit [31:0] d, input string tag);
        step(1, 1, a, be, d, 0, 0, 0, tag);
    endtask
    task automatic rd(input bit [7:0] a, input bit [3:0] be, input string tag);
        step(1, 0, a, be, 0, 0, 0, 0, tag);
    endtask
    task automatic ev(input bit [1:0] eh, input bit [1:0] eu, input bit [1:0] ef, input string tag);
        step(0, 0, 0, 0, 0, eh, eu, ef, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R11 reset"); idle("R11 reset");

        // R1 / R10 data registers and lane enables
        wr(8'h84, 4'h3, 32'h0000_BEEF, "R1");
        rd(8'h84, 4'hF, "R1");
        wr(8'hA4, 4'h3, 32'h0000_0101, "R10");
        rd(8'h84, 4'hF, "R10");
        rd(8'hA4, 4'hF, "R10");
        wr(8'h94, 4'hF, 32'h2222_1111, "R1");
        rd(8'h94, 4'hF, "R1");
        wr(8'h94, 4'h4, 32'h0033_0000, "R1");
        rd(8'h94, 4'hF, "R1");

        // R9 pointer alignment
        wr(8'h8C, 4'hF, 32'h1234_567F, "R9");
        rd(8'h8C, 4'hF, "R9");
        wr(8'h8C, 4'h1, 32'h0000_00FF, "R9");
        rd(8'h8C, 4'hF, "R9");

        // R3/R4 start before key, wrong key, right key
        wr(8'h80, 4'h3, 32'h0000_0083, "R3 no key");
        rd(8'h80, 4'hF, "R2");
        wr(8'hC4, 4'h8, 32'h0500_0000, "R4 wrong key");
        rd(8'hC4, 4'hF, "R4");
        wr(8'h80, 4'h1, 32'h0000_0083, "R4 still open");
        wr(8'hC4, 4'h8, 32'h0700_0000, "R4 key");
        rd(8'hC4, 4'hF, "R4");
        wr(8'h80, 4'h1, 32'h0000_0083, "R3 go");
        idle("R3 pulse");
        wr(8'hA0, 4'h1, 32'h0000_0082, "R3 ch1");
        wr(8'hA0, 4'h1, 32'h0000_0082, "R3 back-to-back");
        idle("R3"); idle("R3");

        // R7 reset bit
        wr(8'h80, 4'h1, 32'h0000_00A3, "R7 go+reset");
        ev(2'b11, 2'b11, 2'b11, "R7 events");
        rd(8'h80, 4'hF, "R7");
        wr(8'h80, 4'h1, 32'h0000_0083, "R7 release");
        idle("R7");

        // R5/R6 accumulation and read-clear
        ev(2'b01, 2'b00, 2'b00, "R5");
        ev(2'b00, 2'b01, 2'b00, "R5");
        rd(8'h80, 4'hF, "R6");
        idle("R6");
        rd(8'h80, 4'hF, "R6 cleared");
        ev(2'b01, 2'b00, 2'b00, "R6");
        step(1, 0, 8'h80, 4'h4, 0, 2'b00, 2'b00, 2'b01, "R6 collide");
        rd(8'h80, 4'hF, "R6 survivor");
        ev(2'b00, 2'b01, 2'b00, "R6");
        rd(8'h80, 4'h3, "R6 no lane2");
        rd(8'h80, 4'hF, "R6 lane2");

        // R8 mask on channel 1
        wr(8'hA0, 4'h2, 32'h0000_0100, "R8 mask");
        ev(2'b10, 2'b00, 2'b10, "R8 masked");
        rd(8'hA0, 4'h3, "R5 ch1");
        wr(8'hA0, 4'h2, 32'h0000_0000, "R8 unmask");
        idle("R8");
        rd(8'hA0, 4'hF, "R8 clear");
        idle("R8");

        // R11 unmapped
        rd(8'h60, 4'hF, "R11");
        rd(8'hB8, 4'hF, "R11");
        rd(8'hC0, 4'hF, "R11");
        idle("R11"); idle("R11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule